// File: doc/BRIEF.md
# Dual-Edge Read Capture FIFO

This block takes double-data-rate read data returned by a memory device and moves it into the controller clock domain. The device drives a data strobe that runs only during a read burst. A delay line outside this block shifts the strobe to the centre of the data eye, and the delayed strobe is the block's write clock. On every rising strobe edge the data bus is stored in a rise queue. On every falling edge it is stored in a separate fall queue. Each queue has sixteen entries.

Writes happen only while a capture-enable input is high. That input is timed by a loopback path that matches the board round trip. A rising edge is accepted when the enable is high at that edge. The falling edge that follows writes only if its rising partner was accepted, so the two queues always hold the same number of entries.

The controller side runs on its own clock. A single read request removes one entry from both queues together. One cycle later the block presents a double-width word: the rise beat is in the low half and the fall beat is in the high half. An empty flag tells the controller when no complete pair is available. The only signals that cross between the two domains are Gray-coded write pointers, each passed through a two-flop synchronizer.

Top module: `rdcap_top`

## Requirements
- R1: After the controller-side reset, `empty_o` is 1 and `rd_valid_o` is 0, and they stay so while no strobe edge has been written.
- R2: The value on `dq_i` at an accepted rising strobe edge appears in bits [DQ_W-1:0] of `rd_word_o`.
- R3: The value on `dq_i` at the falling edge that follows an accepted rising edge appears in bits [2*DQ_W-1:DQ_W] of the same `rd_word_o` as its rising partner.
- R4: A rising edge at which `cap_en_i` is 0 writes nothing, and neither does the falling edge after it. With the queues empty before such edges, `empty_o` stays 1 afterwards.
- R5: A read request while `empty_o` is 1 is ignored. `rd_valid_o` stays 0 in the next cycle, and the next accepted read returns the oldest stored pair.
- R6: An accepted read (`rd_req_i`=1 and `empty_o`=0 at a clock edge) gives `rd_valid_o`=1 for exactly the following cycle, with the pair on `rd_word_o`. Pairs come out in the order they were written.
- R7: Sixteen pairs written in one burst into empty queues are all read back in order, and `empty_o` is 1 after the sixteenth read.
- R8: `empty_o` falls within a few controller cycles after a pair is written, through a two-stage synchronizer. It rises in the cycle after the last stored pair is read.
- R9: Pointers wrap modulo the depth, so bursts whose total exceeds sixteen read back in order when they are drained between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strobe_i | input | 1 | Delayed read data strobe, used as the write clock on both edges |
| strobe_rst_i | input | 1 | Synchronous reset of the strobe domain, active high |
| cap_en_i | input | 1 | Loopback-timed capture enable, sampled at rising strobe edges |
| dq_i | input | DQ_W | Read data bus from the memory device |
| clk_i | input | 1 | Controller clock |
| rst_i | input | 1 | Synchronous reset of the controller domain, active high |
| rd_req_i | input | 1 | Request to pop one rise/fall pair |
| rd_word_o | output | 2*DQ_W | Popped pair: rise beat in the low half, fall beat in the high half |
| rd_valid_o | output | 1 | High for one cycle when `rd_word_o` carries a popped pair |
| empty_o | output | 1 | No complete pair is visible to the controller domain |

## Verification
The assertions take three things for granted about the inputs. The strobe period is no shorter than the controller clock period, so a synchronized pointer moves by at most one Gray step per controller cycle. `cap_en_i` changes only away from rising strobe edges. The controller never lets more than sixteen pairs be outstanding. The stimulus meets these limits. It drives the strobe at a 10 ns period against an 8 ns clock, and it changes `cap_en_i` and `dq_i` mid-phase, a quarter period before each strobe edge. Every burst is drained before the next one pushes the number of stored pairs past sixteen, and each strobe-domain reset is held across several full strobe cycles while the enable stays low.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } cap_edge_e;

    localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/rdcap_sync.sv
module rdcap_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk_i) begin
        for (int k = 0; k < STAGES; k++) begin
            if (rst_i) begin
                stg_q[k] <= '0;
            end else if (k == 0) begin
                stg_q[k] <= async_i;
            end else begin
                stg_q[k] <= stg_q[k-1];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/rdcap_edge_fifo.sv
module rdcap_edge_fifo
    import rdcap_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    parameter cap_edge_e   EDGE  = EDGE_RISE,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          wr_clk_i,
    input  logic          wr_rst_i,
    input  logic          wr_en_i,
    input  logic [W-1:0]  wr_data_i,
    output logic [PW-1:0] wr_gray_o,
    output logic [PW-1:0] wr_bin_o,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_data_o
);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wptr_t;

    wptr_t        st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (wr_rst_i) begin
            st_d = '0;
        end else if (wr_en_i) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        end
    end

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            always_ff @(posedge wr_clk_i) begin
                st_q <= st_d;
                if (wr_en_i && !wr_rst_i) begin
                    mem_q[st_q.bin[AW-1:0]] <= wr_data_i;
                end
            end
        end else begin : g_fall
            always_ff @(negedge wr_clk_i) begin
                st_q <= st_d;
                if (wr_en_i && !wr_rst_i) begin
                    mem_q[st_q.bin[AW-1:0]] <= wr_data_i;
                end
            end
        end
    endgenerate

    assign wr_gray_o = st_q.gray;
    assign wr_bin_o  = st_q.bin;
    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/rdcap_rd_ctrl.sv
module rdcap_rd_ctrl #(
    parameter int unsigned W           = 8,
    parameter int unsigned AW          = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PW         = AW + 1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          rd_req_i,
    input  logic [PW-1:0] rise_gray_i,
    input  logic [PW-1:0] fall_gray_i,
    input  logic [W-1:0]  rise_data_i,
    input  logic [W-1:0]  fall_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [2*W-1:0] rd_word_o,
    output logic          rd_valid_o,
    output logic          empty_o
);

    typedef struct packed {
        logic [PW-1:0]  ptr;
        logic [2*W-1:0] word;
        logic           valid;
    } rstate_t;

    rstate_t       st_d, st_q;
    logic [PW-1:0] rise_sync, fall_sync, rd_gray;
    logic          pop;

    rdcap_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_rise (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i(rise_gray_i),
        .sync_o (rise_sync)
    );

    rdcap_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_fall (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i(fall_gray_i),
        .sync_o (fall_sync)
    );

    always_comb begin
        rd_gray = st_q.ptr ^ (st_q.ptr >> 1);
        empty_o = (rd_gray == rise_sync) || (rd_gray == fall_sync);
        pop     = rd_req_i && !empty_o;
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (rst_i) begin
            st_d = '0;
        end else if (pop) begin
            st_d.ptr   = st_q.ptr + 1'b1;
            st_d.word  = {fall_data_i, rise_data_i};
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign rd_addr_o  = st_q.ptr[AW-1:0];
    assign rd_word_o  = st_q.word;
    assign rd_valid_o = st_q.valid;

    // R8: each synchronized write pointer moves by at most one Gray step per cycle
    p_sync_step_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(rise_sync ^ $past(rise_sync)) && $onehot0(fall_sync ^ $past(fall_sync)));

    // R5: a request against an empty queue leaves the pointer alone and gives no valid
    p_empty_ignored_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_req_i && empty_o) |=> ($stable(st_q.ptr) && !rd_valid_o));

    // R6: valid only follows a request
    p_valid_after_req_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_valid_o |-> $past(rd_req_i));

endmodule

// File: rtl/rdcap_top.sv
module rdcap_top
    import rdcap_pkg::*;
#(
    parameter int unsigned DQ_W        = 8,
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    localparam int unsigned AW         = $clog2(DEPTH),
    localparam int unsigned PW         = AW + 1
) (
    input  logic              strobe_i,
    input  logic              strobe_rst_i,
    input  logic              cap_en_i,
    input  logic [DQ_W-1:0]   dq_i,
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_req_i,
    output logic [2*DQ_W-1:0] rd_word_o,
    output logic              rd_valid_o,
    output logic              empty_o
);

    logic            hit_d, hit_q;
    logic [PW-1:0]   rise_gray, fall_gray, rise_bin, fall_bin;
    logic [AW-1:0]   rd_addr;
    logic [DQ_W-1:0] rise_data, fall_data;

    // A falling edge writes only when its rising partner was accepted.
    always_comb begin
        hit_d = strobe_rst_i ? 1'b0 : cap_en_i;
    end

    always_ff @(posedge strobe_i) begin
        hit_q <= hit_d;
    end

    rdcap_edge_fifo #(.W(DQ_W), .DEPTH(DEPTH), .EDGE(EDGE_RISE)) u_rise (
        .wr_clk_i (strobe_i),
        .wr_rst_i (strobe_rst_i),
        .wr_en_i  (cap_en_i),
        .wr_data_i(dq_i),
        .wr_gray_o(rise_gray),
        .wr_bin_o (rise_bin),
        .rd_addr_i(rd_addr),
        .rd_data_o(rise_data)
    );

    rdcap_edge_fifo #(.W(DQ_W), .DEPTH(DEPTH), .EDGE(EDGE_FALL)) u_fall (
        .wr_clk_i (strobe_i),
        .wr_rst_i (strobe_rst_i),
        .wr_en_i  (hit_q),
        .wr_data_i(dq_i),
        .wr_gray_o(fall_gray),
        .wr_bin_o (fall_bin),
        .rd_addr_i(rd_addr),
        .rd_data_o(fall_data)
    );

    rdcap_rd_ctrl #(.W(DQ_W), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rd_req_i   (rd_req_i),
        .rise_gray_i(rise_gray),
        .fall_gray_i(fall_gray),
        .rise_data_i(rise_data),
        .fall_data_i(fall_data),
        .rd_addr_o  (rd_addr),
        .rd_word_o  (rd_word_o),
        .rd_valid_o (rd_valid_o),
        .empty_o    (empty_o)
    );

    // R3: before each rising edge both queues hold the same number of beats
    p_pair_balance_r3: assert property (@(posedge strobe_i) disable iff (strobe_rst_i)
        rise_bin == fall_bin);

    // R4: a rising edge without enable leaves the rise pointer unchanged
    p_gate_closed_r4: assert property (@(posedge strobe_i) disable iff (strobe_rst_i)
        !cap_en_i |=> $stable(rise_bin));

endmodule

// File: tb/sim_rdcap_top.sv
`timescale 1ns/1ps
module sim_rdcap_top;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         strobe = 1'b0;
    logic         srst = 1'b1;
    logic         cap_en = 1'b0;
    logic [W-1:0] dq = '0;
    logic         rd_req = 1'b0;
    logic [2*W-1:0] rd_word;
    logic         rd_valid;
    logic         empty;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] exp_r [64];
    logic [W-1:0] exp_f [64];
    int head = 0;
    int tail = 0;

    always #4 clk = ~clk;

    rdcap_top u0 (
        .strobe_i    (strobe),
        .strobe_rst_i(srst),
        .cap_en_i    (cap_en),
        .dq_i        (dq),
        .clk_i       (clk),
        .rst_i       (rst),
        .rd_req_i    (rd_req),
        .rd_word_o   (rd_word),
        .rd_valid_o  (rd_valid),
        .empty_o     (empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic strobe_cycle(input logic [W-1:0] r, input logic [W-1:0] f, input logic en);
        dq = r; cap_en = en;
        #2.5 strobe = 1'b1;
        #2.5 dq = f;
        #2.5 strobe = 1'b0;
        #2.5 cap_en = 1'b0;
    endtask

    task automatic burst(input int n, input logic [W-1:0] base);
        for (int i = 0; i < n; i++) begin
            exp_r[tail % 64] = base + W'(i);
            exp_f[tail % 64] = ~(base + W'(i));
            tail++;
            strobe_cycle(base + W'(i), ~(base + W'(i)), 1'b1);
        end
        cap_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic read_one(input string tag);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        chk({tag, " R6 valid"}, 32'(rd_valid), 32'd1);
        chk({tag, " R2 rise half"}, 32'(rd_word[W-1:0]), 32'(exp_r[head % 64]));
        chk({tag, " R3 fall half"}, 32'(rd_word[2*W-1:W]), 32'(exp_f[head % 64]));
        head++;
    endtask

    task automatic t_reset();
        repeat (3) strobe_cycle(8'h11, 8'h22, 1'b0);
        srst = 1'b0;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R1 empty after reset", 32'(empty), 32'd1);
        chk("R1 valid after reset", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_empty_read();
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        chk("R5 valid on empty read", 32'(rd_valid), 32'd0);
        chk("R5 empty stays", 32'(empty), 32'd1);
    endtask

    task automatic t_gated();
        strobe_cycle(8'h5A, 8'hA5, 1'b0);
        strobe_cycle(8'h3C, 8'hC3, 1'b0);
        settle();
        chk("R4 empty after gated edges", 32'(empty), 32'd1);
    endtask

    task automatic t_basic();
        strobe_cycle(8'hEE, 8'hDD, 1'b0);
        burst(4, 8'h40);
        strobe_cycle(8'h77, 8'h88, 1'b0);
        settle();
        chk("R8 empty falls after write", 32'(empty), 32'd0);
        read_one("basic0");
        @(negedge clk);
        chk("R6 valid is one pulse", 32'(rd_valid), 32'd0);
        for (int i = 1; i < 4; i++) read_one("basic");
        chk("R8 empty after last read", 32'(empty), 32'd1);
        t_empty_read();
    endtask

    task automatic t_empty_then_data();
        t_empty_read();
        burst(2, 8'h90);
        settle();
        read_one("R5 oldest after ignored read");
        read_one("R5 second");
        chk("R5 drained", 32'(empty), 32'd1);
    endtask

    task automatic t_full();
        burst(16, 8'h10);
        settle();
        for (int i = 0; i < 16; i++) read_one("R7 depth");
        chk("R7 empty after sixteen", 32'(empty), 32'd1);
    endtask

    task automatic t_wrap();
        burst(6, 8'hC0);
        settle();
        for (int i = 0; i < 6; i++) read_one("R9 wrap a");
        burst(13, 8'h60);
        settle();
        for (int i = 0; i < 13; i++) read_one("R9 wrap b");
        chk("R9 empty after wrap", 32'(empty), 32'd1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_empty_read();
        t_gated();
        t_basic();
        t_empty_then_data();
        t_full();
        t_wrap();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule